// File: doc/BRIEF.md
# Address register effective-address unit

This block keeps a file of eight 32-bit address registers. It resolves the location of an operand for three addressing modes. A request carries a 3-bit mode code, a 3-bit register number, a 2-bit size code and an 8-bit coprocessor byte count, and is qualified by a start strobe. One clock later the block returns a single-cycle result with these parts:

- a done pulse;
- a flag that tells whether the operand is the register itself or lies in memory;
- the 32-bit register contents, or the 32-bit memory address.

None of the supported modes needs extension words.

In postincrement mode the address handed out is the register's current value. The register is then advanced by the operand length on the following clock edge. The adder wraps at 32 bits. A result that is still waiting to be written is forwarded to a request issued in the next cycle, so back-to-back requests through the same register see the advanced pointer. A separate load port presets any register.

An unsupported mode code gives an illegal-mode pulse. A zero coprocessor count in postincrement gives a count-error pulse. Neither of them changes any register.

Top module: `ea_unit`

## Requirements
- R1: After reset every register reads as zero, and done_o, in_mem_o, illegal_o, count_err_o and value_o are all zero.
- R2: Mode code 3'b001 (register direct) gives, in the cycle after start_i, done_o=1, in_mem_o=0 and value_o equal to the selected register.
- R3: Mode code 3'b010 (register indirect) gives, in the cycle after start_i, done_o=1, in_mem_o=1 and value_o equal to the selected register, and it leaves that register unchanged.
- R4: Mode code 3'b011 (postincrement) gives done_o=1, in_mem_o=1 and value_o equal to the register's value before the access. The register then grows by 1, 2 or 4 for size_i codes 2'b00 (byte), 2'b01 (word) and 2'b10 (long word).
- R5: A byte postincrement (size_i=2'b00) through register 7 (the stack pointer) grows the register by 2.
- R6: With size_i=2'b11, postincrement grows the register by cp_count_i, for any value from 1 to 255. This holds for register 7 as well.
- R7: A postincrement with size_i=2'b11 and cp_count_i=0 gives count_err_o=1 for one cycle, with done_o=0 and value_o=0, and it changes no register.
- R8: A mode code of 3'b000 or 3'b100 through 3'b111 gives illegal_o=1 for one cycle, with done_o=0 and value_o=0, and it changes no register.
- R9: The postincrement addition wraps modulo 2^32.
- R10: A request issued in the cycle right after a postincrement on the same register uses the advanced value.
- R11: When ld_en_i is high, ld_data_i is written into register ld_idx_i at the clock edge. If that edge also carries a pending postincrement write to the same register, the loaded value is kept.
- R12: done_o, illegal_o and count_err_o are single-cycle pulses, are mutually exclusive, and stay low in any cycle that follows a cycle without start_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing mode code |
| reg_i | input | 3 | Address register number |
| size_i | input | 2 | Operand size code |
| cp_count_i | input | 8 | Coprocessor byte count for size code 2'b11 |
| ld_en_i | input | 1 | Register preset enable |
| ld_idx_i | input | 3 | Register preset index |
| ld_data_i | input | 32 | Register preset data |
| done_o | output | 1 | Result valid pulse |
| in_mem_o | output | 1 | Operand is in memory at value_o |
| value_o | output | 32 | Register contents or effective address |
| illegal_o | output | 1 | Unsupported mode pulse |
| count_err_o | output | 1 | Zero coprocessor count pulse |

## Verification
The hardest case to reach from the ports is a collision between the deferred postincrement write-back and the next event on the same register. That next event is either a new request, which must be forwarded the advanced value, or a preset, which must win. The bench reaches both by timing inputs to the half cycle: it issues a postincrement, then drives either a second request or a load to the same register on the very next cycle. It afterwards reads the register back through an indirect request. Table vectors cover the remaining cases, including the stack-pointer byte rule, the 255 and 1 coprocessor counts and a wrap past 2^32.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    MODE_AREG    = 3'b001,
    MODE_IND     = 3'b010,
    MODE_POSTINC = 3'b011
  } mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_LONG  = 2'b10,
    SZ_COPRO = 2'b11
  } size_e;

  typedef struct packed {
    logic is_direct;
    logic is_indirect;
    logic is_postinc;
    logic illegal;
  } mode_dec_t;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [2:0] mode_i,
  output mode_dec_t  dec_o
);
  always_comb begin
    dec_o = '0;
    unique case (mode_i)
      MODE_AREG:    dec_o.is_direct   = 1'b1;
      MODE_IND:     dec_o.is_indirect = 1'b1;
      MODE_POSTINC: dec_o.is_postinc  = 1'b1;
      default:      dec_o.illegal     = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_step.sv
module ea_step
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 8,
  parameter int SP_IDX = 7
) (
  input  logic [1:0]       size_i,
  input  logic [IDX_W-1:0] reg_i,
  input  logic [CNT_W-1:0] cp_count_i,
  output logic [ADDR_W-1:0] step_o,
  output logic             zero_cnt_o
);
  logic is_sp;
  assign is_sp = (reg_i == IDX_W'(SP_IDX));

  always_comb begin
    step_o     = '0;
    zero_cnt_o = 1'b0;
    unique case (size_e'(size_i))
      SZ_BYTE:  step_o = is_sp ? ADDR_W'(2) : ADDR_W'(1);
      SZ_WORD:  step_o = ADDR_W'(2);
      SZ_LONG:  step_o = ADDR_W'(4);
      SZ_COPRO: begin
        step_o     = ADDR_W'(cp_count_i);
        zero_cnt_o = (cp_count_i == '0);
      end
      default:  step_o = '0;
    endcase
  end
endmodule

// File: rtl/ea_regfile.sv
module ea_regfile #(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_en_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [ADDR_W-1:0] ld_data_i,
  input  logic              wb_en_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  input  logic [ADDR_W-1:0] wb_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_data_o
);
  logic [ADDR_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic ld_hit, wb_hit;
    assign ld_hit = ld_en_i && (ld_idx_i == IDX_W'(g));
    assign wb_hit = wb_en_i && (wb_idx_i == IDX_W'(g));
    // load port has priority over write-back
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     regs_q[g] <= '0;
      else if (ld_hit) regs_q[g] <= ld_data_i;
      else if (wb_hit) regs_q[g] <= wb_data_i;
    end
  end

  assign rd_data_o = regs_q[rd_idx_i];
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 8,
  parameter int SP_IDX   = 7,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic [IDX_W-1:0]  reg_i,
  input  logic [1:0]        size_i,
  input  logic [CNT_W-1:0]  cp_count_i,
  input  logic              ld_en_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [ADDR_W-1:0] ld_data_i,
  output logic              done_o,
  output logic              in_mem_o,
  output logic [ADDR_W-1:0] value_o,
  output logic              illegal_o,
  output logic              count_err_o
);
  mode_dec_t         dec;
  logic [ADDR_W-1:0] step;
  logic              zero_cnt;
  logic [ADDR_W-1:0] rd_raw, opnd;

  logic              wb_pend_q;
  logic [IDX_W-1:0]  wb_idx_q;
  logic [ADDR_W-1:0] wb_val_q;

  logic              ok, cnt_bad;

  ea_decode u_dec (
    .mode_i (mode_i),
    .dec_o  (dec)
  );

  ea_step #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W),
    .SP_IDX (SP_IDX)
  ) u_step (
    .size_i     (size_i),
    .reg_i      (reg_i),
    .cp_count_i (cp_count_i),
    .step_o     (step),
    .zero_cnt_o (zero_cnt)
  );

  ea_regfile #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W)
  ) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_en_i   (ld_en_i),
    .ld_idx_i  (ld_idx_i),
    .ld_data_i (ld_data_i),
    .wb_en_i   (wb_pend_q),
    .wb_idx_i  (wb_idx_q),
    .wb_data_i (wb_val_q),
    .rd_idx_i  (reg_i),
    .rd_data_o (rd_raw)
  );

  // forward a write-back that has not landed yet
  assign opnd    = (wb_pend_q && (wb_idx_q == reg_i)) ? wb_val_q : rd_raw;
  assign cnt_bad = dec.is_postinc && zero_cnt;
  assign ok      = !dec.illegal && !cnt_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      in_mem_o    <= 1'b0;
      value_o     <= '0;
      illegal_o   <= 1'b0;
      count_err_o <= 1'b0;
    end else begin
      done_o      <= start_i && ok;
      in_mem_o    <= start_i && ok && !dec.is_direct;
      value_o     <= (start_i && ok) ? opnd : '0;
      illegal_o   <= start_i && dec.illegal;
      count_err_o <= start_i && cnt_bad;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_pend_q <= 1'b0;
      wb_idx_q  <= '0;
      wb_val_q  <= '0;
    end else begin
      wb_pend_q <= start_i && dec.is_postinc && !zero_cnt;
      if (start_i && dec.is_postinc) begin
        wb_idx_q <= reg_i;
        wb_val_q <= opnd + step;
      end
    end
  end
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [2:0]        mode_i,
  input logic [IDX_W-1:0]  reg_i,
  input logic [1:0]        size_i,
  input logic [CNT_W-1:0]  cp_count_i,
  input logic              done_o,
  input logic              in_mem_o,
  input logic [ADDR_W-1:0] value_o,
  input logic              illegal_o,
  input logic              count_err_o
);
  logic legal_mode;
  assign legal_mode = (mode_i == 3'b001) || (mode_i == 3'b010) || (mode_i == 3'b011);

  p_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, illegal_o, count_err_o}));

  p_no_start_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o && !illegal_o && !count_err_o);

  p_direct_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && mode_i == 3'b001 |=> done_o && !in_mem_o);

  p_indirect_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && mode_i == 3'b010 |=> done_o && in_mem_o);

  p_cnt_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && mode_i == 3'b011 && size_i == 2'b11 && cp_count_i == '0
    |=> count_err_o && !done_o && value_o == '0);

  p_illegal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !legal_mode |=> illegal_o && !done_o && value_o == '0);
endmodule

bind ea_unit ea_unit_chk #(
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mode_i      (mode_i),
  .reg_i       (reg_i),
  .size_i      (size_i),
  .cp_count_i  (cp_count_i),
  .done_o      (done_o),
  .in_mem_o    (in_mem_o),
  .value_o     (value_o),
  .illegal_o   (illegal_o),
  .count_err_o (count_err_o)
);

// File: tb/tb_ea_unit.sv
`timescale 1ns/1ps
module tb_ea_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [2:0]  reg_i = '0;
  logic [1:0]  size_i = '0;
  logic [7:0]  cp_count_i = '0;
  logic        ld_en_i = 1'b0;
  logic [2:0]  ld_idx_i = '0;
  logic [31:0] ld_data_i = '0;
  logic        done_o, in_mem_o, illegal_o, count_err_o;
  logic [31:0] value_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  ea_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .reg_i(reg_i), .size_i(size_i), .cp_count_i(cp_count_i),
    .ld_en_i(ld_en_i), .ld_idx_i(ld_idx_i), .ld_data_i(ld_data_i),
    .done_o(done_o), .in_mem_o(in_mem_o), .value_o(value_o),
    .illegal_o(illegal_o), .count_err_o(count_err_o)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  mode;
    logic [2:0]  rg;
    logic [1:0]  sz;
    logic [7:0]  cnt;
    logic [31:0] pre;
    logic        done;
    logic        mem;
    logic        ill;
    logic        err;
    logic [31:0] val;
    logic [31:0] after;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{8'd2,  3'd1, 3'd1, 2'd0, 8'd0,   32'h1000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1000_0000, 32'h1000_0000}, // R2
    '{8'd3,  3'd2, 3'd2, 2'd2, 8'd0,   32'h2000_0010, 1'b1, 1'b1, 1'b0, 1'b0, 32'h2000_0010, 32'h2000_0010}, // R3
    '{8'd4,  3'd3, 3'd3, 2'd0, 8'd0,   32'h0000_0100, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0100, 32'h0000_0101}, // R4 byte
    '{8'd4,  3'd3, 3'd4, 2'd1, 8'd0,   32'h0000_0200, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0200, 32'h0000_0202}, // R4 word
    '{8'd4,  3'd3, 3'd5, 2'd2, 8'd0,   32'h0000_0300, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0300, 32'h0000_0304}, // R4 long
    '{8'd5,  3'd3, 3'd7, 2'd0, 8'd0,   32'h0000_0400, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0400, 32'h0000_0402}, // R5
    '{8'd4,  3'd3, 3'd7, 2'd1, 8'd0,   32'h0000_0400, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0400, 32'h0000_0402}, // R4 sp word
    '{8'd6,  3'd3, 3'd6, 2'd3, 8'd255, 32'h0000_0010, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0010, 32'h0000_010F}, // R6 max
    '{8'd6,  3'd3, 3'd7, 2'd3, 8'd1,   32'h0000_0008, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0008, 32'h0000_0009}, // R6 sp count 1
    '{8'd7,  3'd3, 3'd0, 2'd3, 8'd0,   32'h0000_0055, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0,         32'h0000_0055}, // R7
    '{8'd8,  3'd0, 3'd1, 2'd0, 8'd0,   32'h0000_0077, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         32'h0000_0077}, // R8 mode 000
    '{8'd8,  3'd5, 3'd2, 2'd3, 8'd9,   32'h0000_0088, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         32'h0000_0088}, // R8 mode 101
    '{8'd9,  3'd3, 3'd3, 2'd2, 8'd0,   32'hFFFF_FFFE, 1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFE, 32'h0000_0002}  // R9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk_i);
    ld_en_i = 1'b1; ld_idx_i = idx; ld_data_i = d;
    @(negedge clk_i);
    ld_en_i = 1'b0;
  endtask

  // drives a request at a negedge, returns at the next negedge with outputs valid
  task automatic req(input logic [2:0] m, input logic [2:0] r, input logic [1:0] s,
                     input logic [7:0] c);
    @(negedge clk_i);
    start_i = 1'b1; mode_i = m; reg_i = r; size_i = s; cp_count_i = c;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic read_reg(input logic [2:0] r, output logic [31:0] v);
    @(negedge clk_i);
    req(3'b010, r, 2'b00, 8'd0);
    v = value_o;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    // R1: outputs during and after reset
    chk("R1 done", {31'd0, done_o}, 32'd0);
    chk("R1 value", value_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 flags", {28'd0, done_o, in_mem_o, illegal_o, count_err_o}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      read_reg(3'(i), v);
      chk($sformatf("R1 reg%0d", i), v, 32'd0);
    end

    for (int i = 0; i < NV; i++) begin
      vec_t t;
      string tg;
      t = TBL[i];
      tg = $sformatf("R%0d vec%0d", t.req, i);
      load(t.rg, t.pre);
      req(t.mode, t.rg, t.sz, t.cnt);
      chk({tg, " done"}, {31'd0, done_o}, {31'd0, t.done});
      chk({tg, " in_mem"}, {31'd0, in_mem_o}, {31'd0, t.mem});
      chk({tg, " illegal"}, {31'd0, illegal_o}, {31'd0, t.ill});
      chk({tg, " cnt_err"}, {31'd0, count_err_o}, {31'd0, t.err});
      chk({tg, " value"}, value_o, t.val);
      // R12: pulse gone in the idle cycle that follows
      @(negedge clk_i);
      chk({tg, " R12 pulse"}, {29'd0, done_o, illegal_o, count_err_o}, 32'd0);
      read_reg(t.rg, v);
      chk({tg, " reg after"}, v, t.after);
    end

    // R8: illegal mode leaves other registers alone too
    load(3'd4, 32'h0000_4444);
    req(3'b111, 3'd4, 2'b00, 8'd0);
    chk("R8 mode 111 illegal", {31'd0, illegal_o}, 32'd1);
    @(negedge clk_i);
    read_reg(3'd4, v);
    chk("R8 mode 111 reg", v, 32'h0000_4444);

    // R10: back-to-back postincrement on the same register
    load(3'd2, 32'h0000_0040);
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 3'b011; reg_i = 3'd2; size_i = 2'b10; cp_count_i = 8'd0;
    @(negedge clk_i);
    chk("R10 first value", value_o, 32'h0000_0040);
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R10 second value", value_o, 32'h0000_0044);
    @(negedge clk_i);
    read_reg(3'd2, v);
    chk("R10 reg after two", v, 32'h0000_0048);

    // R11: load on the write-back edge wins
    load(3'd4, 32'h0000_0010);
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 3'b011; reg_i = 3'd4; size_i = 2'b00;
    @(negedge clk_i);
    start_i = 1'b0;
    ld_en_i = 1'b1; ld_idx_i = 3'd4; ld_data_i = 32'h0000_0ABC;
    chk("R11 addr", value_o, 32'h0000_0010);
    @(negedge clk_i);
    ld_en_i = 1'b0;
    read_reg(3'd4, v);
    chk("R11 load wins", v, 32'h0000_0ABC);

    // R11: load to another register on the write-back edge, both land
    load(3'd5, 32'h0000_0100);
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 3'b011; reg_i = 3'd5; size_i = 2'b01;
    @(negedge clk_i);
    start_i = 1'b0;
    ld_en_i = 1'b1; ld_idx_i = 3'd6; ld_data_i = 32'h0000_6666;
    @(negedge clk_i);
    ld_en_i = 1'b0;
    read_reg(3'd5, v);
    chk("R11 wb other reg", v, 32'h0000_0102);
    read_reg(3'd6, v);
    chk("R11 load other reg", v, 32'h0000_6666);

    // R12: no start means no pulse
    @(negedge clk_i);
    mode_i = 3'b000;
    @(negedge clk_i);
    chk("R12 idle", {29'd0, done_o, illegal_o, count_err_o}, 32'd0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule